// File: doc/BRIEF.md
# Debug Trigger Register Bank

This block holds the programming state of a small set of hardware breakpoint triggers for a processor core. Software reaches the triggers through one window of four registers: a selector that picks which trigger is visible, a control word for that trigger, a compare value for that trigger, and a spare register that always reads zero. The block stores the control fields of each trigger (debug-only ownership, address/data select, timing, action, chaining, match kind, the four privilege enables, and the execute, load and store enables) and its compare value.

From the stored fields the block drives three enables that tell the fetch, load and store paths whether any trigger needs checking at all, and a one-cycle pulse that asks the address translation cache to flush after a trigger is reprogrammed. A trigger owned by debug mode cannot be changed from outside debug mode. Address comparison and the response to a hit live elsewhere.

Top module: `trig_bank`

## Requirements
- R1: A write to the selector (register index 0) takes effect only when the written value is less than NUM_TRIG; otherwise the selector keeps its value. Reading index 0 returns the selector zero-extended to XLEN.
- R2: Reading the control word (index 1) returns type 2 in bits [XLEN-1:XLEN-4], debug ownership in bit XLEN-5, a mask width of 0 in bits [XLEN-6:XLEN-11], and the stored fields at: select 19, timing 18, action 17:12, chain 11, match 10:7, machine 6, hypervisor 5, supervisor 4, user 3, execute 2, store 1, load 0. All other bits read 0 and are not stored.
- R3: When a written control word has the execute bit (bit 2) set, the timing bit is stored as 0 whatever was written.
- R4: A control-word write is dropped when the selected trigger has debug ownership set and `in_debug` is low; with `in_debug` high it is accepted, and the ownership decision uses the value held before the write.
- R5: The same ownership rule drops writes to the compare value (index 2).
- R6: The compare value of the selected trigger is stored and read back at full XLEN width, separately per trigger.
- R7: The spare register (index 3) always reads 0 and writes to it change nothing.
- R8: `fetch_chk`, `load_chk` and `store_chk` are the OR over all triggers of the stored execute, load and store bits, updated in the cycle after the write edge.
- R9: `flush_pulse` is high for exactly one cycle following each accepted control-word write, and low otherwise.
- R10: After reset the selector is 0, every control word reads as type 2 with all other bits 0, every compare value is 0, and all three enables and `flush_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_debug | input | 1 | Hart is in debug mode |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register index for the write: 0 selector, 1 control, 2 compare, 3 spare |
| wr_data | input | XLEN | Write data |
| rd_addr | input | 2 | Register index for the read |
| rd_data | output | XLEN | Combinational read data |
| fetch_chk | output | 1 | Some trigger has execute enabled |
| load_chk | output | 1 | Some trigger has load enabled |
| store_chk | output | 1 | Some trigger has store enabled |
| flush_pulse | output | 1 | One-cycle request to flush address translation |

## Verification
The ownership check and the field update meet in one cycle when a control word that clears debug ownership is written to a trigger that currently has it set. The bench provokes this both with `in_debug` low, where the write must vanish and no flush pulse may appear, and with `in_debug` high, where the ownership bit must clear and the pulse must follow. A second coincidence is the execute bit and the timing bit arriving in the same word, judged by reading back a timing bit of 0 while the fetch enable rises in the same cycle as the flush pulse.

// File: rtl/trig_pkg.sv
package trig_pkg;

   // Register window indices
   typedef enum logic [1:0] {
      REG_SELECT  = 2'd0,
      REG_CONTROL = 2'd1,
      REG_COMPARE = 2'd2,
      REG_SPARE   = 2'd3
   } trig_reg_e;

   // Trigger kind reported in the top nibble of the control word
   localparam logic [3:0] KIND_ADDR_DATA = 4'd2;
   localparam int unsigned KIND_W    = 4;
   localparam int unsigned MASKW_W   = 6;

   // Low field positions (decoded by the trigger-match logic)
   localparam int unsigned POS_SELECT = 19;
   localparam int unsigned POS_TIMING = 18;
   localparam int unsigned POS_ACT_HI = 17;
   localparam int unsigned POS_ACT_LO = 12;
   localparam int unsigned POS_CHAIN  = 11;
   localparam int unsigned POS_MAT_HI = 10;
   localparam int unsigned POS_MAT_LO = 7;
   localparam int unsigned POS_PRV_M  = 6;
   localparam int unsigned POS_PRV_H  = 5;
   localparam int unsigned POS_PRV_S  = 4;
   localparam int unsigned POS_PRV_U  = 3;
   localparam int unsigned POS_EXEC   = 2;
   localparam int unsigned POS_STORE  = 1;
   localparam int unsigned POS_LOAD   = 0;
   localparam int unsigned LOW_W      = POS_SELECT + 1;

   typedef struct packed {
      logic       dbg_own;
      logic       sel_data;
      logic       after;
      logic [5:0] act;
      logic       chain;
      logic [3:0] mkind;
      logic       en_m;
      logic       en_h;
      logic       en_s;
      logic       en_u;
      logic       on_exec;
      logic       on_store;
      logic       on_load;
   } trig_ctrl_t;

endpackage

// File: rtl/trig_codec.sv
module trig_codec
   import trig_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  trig_ctrl_t        fld_i,
   output logic [XLEN-1:0]   word_o,
   input  logic [LOW_W-1:0]  low_i,
   input  logic              own_i,
   output trig_ctrl_t        fld_o
);

   localparam int unsigned KIND_HI = XLEN - 1;
   localparam int unsigned OWN_POS = XLEN - 1 - KIND_W;
   localparam int unsigned MSK_HI  = OWN_POS - 1;

   // Pack stored fields into the read format
   always_comb begin
      word_o = '0;
      word_o[KIND_HI -: KIND_W]          = KIND_ADDR_DATA;
      word_o[OWN_POS]                    = fld_i.dbg_own;
      word_o[MSK_HI -: MASKW_W]          = '0;
      word_o[POS_SELECT]                 = fld_i.sel_data;
      word_o[POS_TIMING]                 = fld_i.after;
      word_o[POS_ACT_HI:POS_ACT_LO]      = fld_i.act;
      word_o[POS_CHAIN]                  = fld_i.chain;
      word_o[POS_MAT_HI:POS_MAT_LO]      = fld_i.mkind;
      word_o[POS_PRV_M]                  = fld_i.en_m;
      word_o[POS_PRV_H]                  = fld_i.en_h;
      word_o[POS_PRV_S]                  = fld_i.en_s;
      word_o[POS_PRV_U]                  = fld_i.en_u;
      word_o[POS_EXEC]                   = fld_i.on_exec;
      word_o[POS_STORE]                  = fld_i.on_store;
      word_o[POS_LOAD]                   = fld_i.on_load;
   end

   // Unpack a written word; an execute trigger always fires before the access
   always_comb begin
      fld_o.dbg_own  = own_i;
      fld_o.sel_data = low_i[POS_SELECT];
      fld_o.after    = low_i[POS_TIMING] & ~low_i[POS_EXEC];
      fld_o.act      = low_i[POS_ACT_HI:POS_ACT_LO];
      fld_o.chain    = low_i[POS_CHAIN];
      fld_o.mkind    = low_i[POS_MAT_HI:POS_MAT_LO];
      fld_o.en_m     = low_i[POS_PRV_M];
      fld_o.en_h     = low_i[POS_PRV_H];
      fld_o.en_s     = low_i[POS_PRV_S];
      fld_o.en_u     = low_i[POS_PRV_U];
      fld_o.on_exec  = low_i[POS_EXEC];
      fld_o.on_store = low_i[POS_STORE];
      fld_o.on_load  = low_i[POS_LOAD];
   end

endmodule

// File: rtl/trig_slot.sv
module trig_slot
   import trig_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ctrl_we,
   input  logic            cmp_we,
   input  trig_ctrl_t      ctrl_d,
   input  logic [XLEN-1:0] cmp_d,
   output trig_ctrl_t      ctrl_q,
   output logic [XLEN-1:0] cmp_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_we) begin
         ctrl_q <= ctrl_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= '0;
      end else if (cmp_we) begin
         cmp_q <= cmp_d;
      end
   end

endmodule

// File: rtl/trig_aggr.sv
module trig_aggr #(
   parameter int unsigned NUM_TRIG = 4
) (
   input  logic [NUM_TRIG-1:0] exec_v,
   input  logic [NUM_TRIG-1:0] load_v,
   input  logic [NUM_TRIG-1:0] store_v,
   output logic                fetch_any,
   output logic                load_any,
   output logic                store_any
);

   assign fetch_any = |exec_v;
   assign load_any  = |load_v;
   assign store_any = |store_v;

endmodule

// File: rtl/trig_bank.sv
module trig_bank
   import trig_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NUM_TRIG = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_debug,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [XLEN-1:0] wr_data,
   input  logic [1:0]      rd_addr,
   output logic [XLEN-1:0] rd_data,
   output logic            fetch_chk,
   output logic            load_chk,
   output logic            store_chk,
   output logic            flush_pulse
);

   localparam int unsigned SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;
   localparam int unsigned OWN_POS = XLEN - 1 - KIND_W;

   // Elaboration-time parameter checks
   if (NUM_TRIG < 1 || NUM_TRIG > 8) begin : g_bad_num
      $error("trig_bank: NUM_TRIG must lie in 1..8");
   end
   if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
      $error("trig_bank: XLEN must be 32 or 64");
   end

   logic [SEL_W-1:0]  sel_q;
   logic              sel_hit;
   logic              locked;
   logic              ctrl_acc;
   logic              cmp_acc;
   logic              flush_q;
   trig_ctrl_t        cur_ctrl;
   logic [XLEN-1:0]   cur_cmp;
   logic [XLEN-1:0]   cur_word;
   trig_ctrl_t        new_ctrl;
   trig_ctrl_t        slot_ctrl [NUM_TRIG];
   logic [XLEN-1:0]   slot_cmp  [NUM_TRIG];
   logic [NUM_TRIG-1:0] exec_v, load_v, store_v;

   // Selector: only in-range values are taken
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
      end else if (wr_en && wr_addr == REG_SELECT && wr_data < XLEN'(NUM_TRIG)) begin
         sel_q <= wr_data[SEL_W-1:0];
      end
   end

   // Selected-trigger view; no match means out of range and reads as zero
   always_comb begin
      sel_hit  = 1'b0;
      cur_ctrl = '0;
      cur_cmp  = '0;
      for (int i = 0; i < NUM_TRIG; i++) begin
         if (sel_q == SEL_W'(i)) begin
            sel_hit  = 1'b1;
            cur_ctrl = slot_ctrl[i];
            cur_cmp  = slot_cmp[i];
         end
      end
   end

   assign locked   = cur_ctrl.dbg_own && !in_debug;
   assign ctrl_acc = wr_en && wr_addr == REG_CONTROL && sel_hit && !locked;
   assign cmp_acc  = wr_en && wr_addr == REG_COMPARE && sel_hit && !locked;

   trig_codec #(.XLEN(XLEN)) u_codec (
      .fld_i  (cur_ctrl),
      .word_o (cur_word),
      .low_i  (wr_data[LOW_W-1:0]),
      .own_i  (wr_data[OWN_POS]),
      .fld_o  (new_ctrl)
   );

   for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
      logic hit;
      assign hit = (sel_q == SEL_W'(g));

      trig_slot #(.XLEN(XLEN)) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .ctrl_we (ctrl_acc && hit),
         .cmp_we  (cmp_acc && hit),
         .ctrl_d  (new_ctrl),
         .cmp_d   (wr_data),
         .ctrl_q  (slot_ctrl[g]),
         .cmp_q   (slot_cmp[g])
      );

      assign exec_v[g]  = slot_ctrl[g].on_exec;
      assign load_v[g]  = slot_ctrl[g].on_load;
      assign store_v[g] = slot_ctrl[g].on_store;
   end

   trig_aggr #(.NUM_TRIG(NUM_TRIG)) u_aggr (
      .exec_v    (exec_v),
      .load_v    (load_v),
      .store_v   (store_v),
      .fetch_any (fetch_chk),
      .load_any  (load_chk),
      .store_any (store_chk)
   );

   // Translation flush follows every accepted control update
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
      end else begin
         flush_q <= ctrl_acc;
      end
   end
   assign flush_pulse = flush_q;

   always_comb begin
      unique case (trig_reg_e'(rd_addr))
         REG_SELECT:  rd_data = XLEN'(sel_q);
         REG_CONTROL: rd_data = sel_hit ? cur_word : '0;
         REG_COMPARE: rd_data = sel_hit ? cur_cmp : '0;
         default:     rd_data = '0;
      endcase
   end

endmodule

// File: rtl/trig_bank_chk.sv
module trig_bank_chk
   import trig_pkg::*;
#(
   parameter int unsigned XLEN     = 32,
   parameter int unsigned NUM_TRIG = 4,
   parameter int unsigned SEL_W    = 2
) (
   input logic            clk,
   input logic            rst_n,
   input logic            wr_en,
   input logic [1:0]      wr_addr,
   input logic [XLEN-1:0] wr_data,
   input logic [1:0]      rd_addr,
   input logic [XLEN-1:0] rd_data,
   input logic            fetch_chk,
   input logic            load_chk,
   input logic            store_chk,
   input logic            flush_pulse,
   input logic [SEL_W-1:0] sel_q,
   input logic            locked
);

   a_r1_sel_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_SELECT && wr_data >= XLEN'(NUM_TRIG)) |=> $stable(sel_q));

   a_r4_ctrl_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_CONTROL && locked) |=> !flush_pulse);

   a_r9_flush_cause: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past(wr_en && wr_addr == REG_CONTROL));

   a_r8_fetch_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_chk != $past(fetch_chk)) |-> flush_pulse);

   a_r8_load_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (load_chk != $past(load_chk)) |-> flush_pulse);

   a_r8_store_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      (store_chk != $past(store_chk)) |-> flush_pulse);

   a_r3_exec_timing: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_CONTROL && rd_data[POS_EXEC]) |-> !rd_data[POS_TIMING]);

   a_r7_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == REG_SPARE) |-> rd_data == '0);

   a_r10_reset_sel: assert property (@(posedge clk)
      $rose(rst_n) |-> (sel_q == '0 && !flush_pulse));

endmodule

bind trig_bank trig_bank_chk #(
   .XLEN     (XLEN),
   .NUM_TRIG (NUM_TRIG),
   .SEL_W    (SEL_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .rd_addr     (rd_addr),
   .rd_data     (rd_data),
   .fetch_chk   (fetch_chk),
   .load_chk    (load_chk),
   .store_chk   (store_chk),
   .flush_pulse (flush_pulse),
   .sel_q       (sel_q),
   .locked      (locked)
);

// File: tb/tb_trig_bank.sv
module tb_trig_bank;

   localparam int unsigned XLEN = 32;
   localparam int unsigned NT   = 4;
   localparam logic [31:0] KEEP_MASK = 32'h080F_FFFF;
   localparam logic [31:0] KIND_WORD = 32'h2000_0000;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            in_debug = 1'b0;
   logic            wr_en = 1'b0;
   logic [1:0]      wr_addr = 2'd0;
   logic [XLEN-1:0] wr_data = '0;
   logic [1:0]      rd_addr = 2'd0;
   logic [XLEN-1:0] rd_data;
   logic            fetch_chk, load_chk, store_chk, flush_pulse;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] m_ctrl [NT];
   logic [31:0] m_cmp  [NT];
   int          m_sel;

   always #4 clk = ~clk;

   trig_bank #(.XLEN(XLEN), .NUM_TRIG(NT)) dut (
      .clk(clk), .rst_n(rst_n), .in_debug(in_debug),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .fetch_chk(fetch_chk), .load_chk(load_chk), .store_chk(store_chk),
      .flush_pulse(flush_pulse)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at the falling edge; flush is sampled at the next falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d, output logic fl);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      fl = flush_pulse;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   function automatic logic [31:0] ctrl_img(input logic [31:0] d);
      logic [31:0] s;
      s = d & KEEP_MASK;
      if (s[2]) s[18] = 1'b0;
      return s | KIND_WORD;
   endfunction

   function automatic logic [2:0] model_en();
      logic [2:0] e = '0;
      for (int i = 0; i < NT; i++) begin
         e[2] |= m_ctrl[i][2];
         e[1] |= m_ctrl[i][0];
         e[0] |= m_ctrl[i][1];
      end
      return e;
   endfunction

   task automatic chk_enables(input string req);
      logic [2:0] e;
      e = model_en();
      check(req, {fetch_chk, load_chk, store_chk}, e);
   endtask

   task automatic set_sel(input logic [31:0] v);
      logic fl;
      logic [31:0] r;
      wr(2'd0, v, fl);
      if (v < NT) m_sel = int'(v);
      rd(2'd0, r);
      check("R1 select", r, m_sel);
   endtask

   task automatic ctrl_write(input logic [31:0] d, input string req);
      logic fl;
      logic [31:0] r;
      logic acc;
      acc = !(m_ctrl[m_sel][27] && !in_debug);
      wr(2'd1, d, fl);
      if (acc) m_ctrl[m_sel] = ctrl_img(d);
      check({req, " R9 flush"}, fl, acc);
      rd(2'd1, r);
      check({req, " R2 control"}, r, m_ctrl[m_sel]);
      chk_enables({req, " R8 enables"});
   endtask

   task automatic cmp_write(input logic [31:0] d, input string req);
      logic fl;
      logic [31:0] r;
      logic acc;
      acc = !(m_ctrl[m_sel][27] && !in_debug);
      wr(2'd2, d, fl);
      if (acc) m_cmp[m_sel] = d;
      check({req, " R9 no flush on compare"}, fl, 1'b0);
      rd(2'd2, r);
      check({req, " R6 compare"}, r, m_cmp[m_sel]);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=done");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      logic fl;
      for (int i = 0; i < NT; i++) begin m_ctrl[i] = KIND_WORD; m_cmp[i] = '0; end
      m_sel = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      rd(2'd0, r); check("R10 select", r, 0);
      check("R10 flush", flush_pulse, 1'b0);
      chk_enables("R10 enables");
      for (int t = 0; t < NT; t++) begin
         set_sel(t);
         rd(2'd1, r); check("R10 control", r, KIND_WORD);
         rd(2'd2, r); check("R10 compare", r, 0);
      end

      // R1 out-of-range selector values are ignored
      set_sel(2);
      for (int v = NT; v < 16; v++) set_sel(v);
      set_sel(32'hFFFF_FFFF);
      set_sel(32'h8000_0001);

      // R3 execute forces timing
      set_sel(0);
      ctrl_write(32'h0004_0004, "R3 exec+timing");
      rd(2'd1, r); check("R3 timing cleared", r[18], 1'b0);
      ctrl_write(32'h0004_0000, "R3 timing alone");
      ctrl_write(32'hF7F0_0000, "R2 unstored bits");

      // Sweep all triggers with computed patterns, in debug mode
      in_debug = 1'b1;
      for (int t = 0; t < NT; t++) begin
         set_sel(t);
         for (int p = 0; p < 8; p++) begin
            logic [31:0] d;
            d = 32'h9E37_79B9 * (t * 8 + p + 1);
            ctrl_write(d, "R2 sweep");
            cmp_write(d ^ 32'h5A5A_A5A5, "R6 sweep");
         end
      end

      // R4/R5 ownership lock
      set_sel(1);
      ctrl_write(32'h0800_0007, "R4 own set");
      in_debug = 1'b0;
      ctrl_write(32'h0000_0000, "R4 locked clear");
      check("R4 still owned", m_ctrl[1][27], 1'b1);
      cmp_write(32'hDEAD_BEEF, "R5 locked compare");
      set_sel(2);
      ctrl_write(32'h0000_0005, "R4 other slot free");
      cmp_write(32'h1234_5678, "R5 other slot free");
      set_sel(1);
      in_debug = 1'b1;
      ctrl_write(32'h0000_0000, "R4 debug clears own");
      in_debug = 1'b0;
      ctrl_write(32'h0000_0002, "R4 unlocked");
      cmp_write(32'hCAFE_F00D, "R5 unlocked");

      // R8 clear everything and watch enables fall
      for (int t = 0; t < NT; t++) begin
         set_sel(t);
         if (m_ctrl[t][27]) in_debug = 1'b1;
         ctrl_write(32'h0, "R8 clear");
         in_debug = 1'b0;
      end

      // R7 spare register
      wr(2'd3, 32'hFFFF_FFFF, fl);
      check("R7 spare no flush", fl, 1'b0);
      rd(2'd3, r); check("R7 spare read", r, 0);
      rd(2'd0, r); check("R7 select untouched", r, m_sel);
      rd(2'd1, r); check("R7 control untouched", r, m_ctrl[m_sel]);
      rd(2'd2, r); check("R7 compare untouched", r, m_cmp[m_sel]);

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule